// File: doc/BRIEF.md
# Program Interrupt Completion Unit

This unit finishes the delivery of a program interrupt once the interrupting condition is known. It receives the 16-bit interruption code, the instruction length, the current PSW mask and instruction address, a pending event-monitor identifier with its event address, a stored translation-exception code and the breaking-event address. From these it works out whether the old-PSW address moves past the instruction, which depends on the exception class. It merges any pending event-monitor condition into the final code and writes the interruption record into a save area. It then loads the new PSW that software placed in that save area.

The save area is a small register file inside the block. Software fills the new-PSW slots through a preload port while the unit is idle. A sequence starts on a one-cycle `start` pulse. It captures all inputs, spends one cycle adjusting, makes one save-area write per cycle, spends one cycle loading the new PSW, and then pulses `done` with the new PSW present on the outputs.

Top module: `pgm_int_complete`

## Requirements
- R1: After reset `busy`, `done`, `sa_we`, `len_err`, `evt_ack`, `psw_mask_o` and `psw_addr_o` are all zero.
- R2: `len_err` is set by a sequence unless the length is 2, 4 or 6, or the length is 0 and the code is the specification code 0x0006. It holds its value until the next sequence decides it.
- R3: Translation-class codes (0x0010 segment, 0x0011 page, 0x0038 address-space-control type, 0x0039..0x003B region first/second/third) leave the old-PSW address equal to the input address and write the translation-exception code to slot 4.
- R4: The protection code 0x0004 writes the translation-exception code to slot 4 and advances the old-PSW address by the length.
- R5: Completing codes advance the old-PSW address by the length, modulo 2^ADDR_W, and write nothing to slot 4. These codes are 0x0001..0x000F except 0x0004, plus 0x0012, 0x0013, 0x0015, 0x001D, 0x001F, 0x0028 and the monitor code 0x0040.
- R6: The event-monitor code 0x0080 and any code not listed in R3..R5 cause no advance and no slot-4 write.
- R7: With a nonzero event identifier, the final code is the input code ORed with 0x0080. The event address goes to slot 5 and the identifier to slot 6, and `evt_ack` pulses together with `done` to clear the pending identifier. With a zero identifier the code passes through unchanged and `evt_ack` stays low.
- R8: Save-area writes appear on `sa_we`/`sa_idx`/`sa_wdata`, one per cycle, in this order: slot 5, slot 6, slot 4 (each only when enabled), then slot 7 length, slot 8 final code, slot 0 old mask and slot 1 old address.
- R9: Every sequence ends its writes with the breaking-event address to slot 9.
- R10: `done` lasts one cycle. A `start` pulse while `busy` is ignored, and `busy` drops the cycle after `done`.
- R11: At `done`, `psw_mask_o`/`psw_addr_o` equal slots 2 and 3 of the save area. Preload writes made while `busy` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to complete an interrupt |
| code_i | input | 16 | Interruption code |
| ilen_i | input | LEN_W | Instruction length in bytes |
| psw_mask_i | input | DATA_W | Current PSW mask |
| psw_addr_i | input | ADDR_W | Current instruction address |
| evt_id_i | input | 16 | Pending event-monitor identifier, zero when none |
| evt_addr_i | input | ADDR_W | Event address |
| tec_i | input | DATA_W | Stored translation-exception code |
| bea_i | input | ADDR_W | Breaking-event address |
| pre_we | input | 1 | Save-area preload strobe |
| pre_idx | input | 4 | Preload slot |
| pre_data | input | DATA_W | Preload data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | New PSW valid, one cycle |
| evt_ack | output | 1 | Pending event identifier consumed |
| len_err | output | 1 | Illegal length/code combination |
| old_addr_o | output | ADDR_W | Adjusted old-PSW address |
| final_code_o | output | 16 | Final interruption code |
| ilen_o | output | LEN_W | Length field stored |
| sa_we | output | 1 | Save-area write strobe |
| sa_idx | output | 4 | Save-area slot written |
| sa_wdata | output | DATA_W | Save-area write data |
| psw_mask_o | output | DATA_W | Current PSW mask after load |
| psw_addr_o | output | ADDR_W | Current PSW address after load |

## Verification
The assertions assume that `start` only counts as a request when the unit is idle. They also assume that the captured address and length are the only source of the adjusted address, so each check compares the result against the values the checker recorded at acceptance. The stimulus issues each request only after the previous `done` and preloads the new PSW only while idle, except in one deliberate run that pulses `start` and a preload mid-sequence to show both are dropped. The sweep covers every listed code, several unlisted ones and the event code. Each is tried with lengths 0, 1, 2, 4 and 6, with and without a pending event, and with addresses near the top of the range so that wrap-around is exercised.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int CODE_W   = 16;
  localparam int SLOT_CNT = 10;
  localparam int SLOT_W   = $clog2(SLOT_CNT);
  localparam int STEP_CNT = 8;
  localparam int STEP_W   = $clog2(STEP_CNT);

  typedef logic [CODE_W-1:0] code_t;

  // interruption codes
  localparam code_t IC_OPER    = 16'h0001;
  localparam code_t IC_PRIV    = 16'h0002;
  localparam code_t IC_EXEC    = 16'h0003;
  localparam code_t IC_PROT    = 16'h0004;
  localparam code_t IC_ADDR    = 16'h0005;
  localparam code_t IC_SPEC    = 16'h0006;
  localparam code_t IC_DATA    = 16'h0007;
  localparam code_t IC_FXOVF   = 16'h0008;
  localparam code_t IC_FXDIV   = 16'h0009;
  localparam code_t IC_DCOVF   = 16'h000A;
  localparam code_t IC_DCDIV   = 16'h000B;
  localparam code_t IC_HEXOVF  = 16'h000C;
  localparam code_t IC_HEXUNF  = 16'h000D;
  localparam code_t IC_HSIG    = 16'h000E;
  localparam code_t IC_HDIV    = 16'h000F;
  localparam code_t IC_SEGX    = 16'h0010;
  localparam code_t IC_PAGEX   = 16'h0011;
  localparam code_t IC_XSPEC   = 16'h0012;
  localparam code_t IC_SPOP    = 16'h0013;
  localparam code_t IC_OPND    = 16'h0015;
  localparam code_t IC_HSQRT   = 16'h001D;
  localparam code_t IC_PCXSPEC = 16'h001F;
  localparam code_t IC_ALSPEC  = 16'h0028;
  localparam code_t IC_ASCTYPE = 16'h0038;
  localparam code_t IC_RGN1X   = 16'h0039;
  localparam code_t IC_RGN2X   = 16'h003A;
  localparam code_t IC_RGN3X   = 16'h003B;
  localparam code_t IC_MONITOR = 16'h0040;
  localparam code_t IC_EVENT   = 16'h0080;

  // save-area slots
  localparam logic [SLOT_W-1:0] SLOT_OLD_MASK = 4'd0;
  localparam logic [SLOT_W-1:0] SLOT_OLD_ADDR = 4'd1;
  localparam logic [SLOT_W-1:0] SLOT_NEW_MASK = 4'd2;
  localparam logic [SLOT_W-1:0] SLOT_NEW_ADDR = 4'd3;
  localparam logic [SLOT_W-1:0] SLOT_TEC      = 4'd4;
  localparam logic [SLOT_W-1:0] SLOT_EVT_ADDR = 4'd5;
  localparam logic [SLOT_W-1:0] SLOT_EVT_ID   = 4'd6;
  localparam logic [SLOT_W-1:0] SLOT_ILEN     = 4'd7;
  localparam logic [SLOT_W-1:0] SLOT_CODE     = 4'd8;
  localparam logic [SLOT_W-1:0] SLOT_BEA      = 4'd9;

  // write steps, in issue order
  localparam int STEP_EVT_ADDR = 0;
  localparam int STEP_EVT_ID   = 1;
  localparam int STEP_TEC      = 2;
  localparam int STEP_ILEN     = 3;
  localparam int STEP_CODE     = 4;
  localparam int STEP_OMASK    = 5;
  localparam int STEP_OADDR    = 6;
  localparam int STEP_BEA      = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADJUST, ST_STORE, ST_LOAD_NEW, ST_DONE
  } state_e;

  typedef enum logic [1:0] {
    CLS_NONE, CLS_XLATE, CLS_PROT, CLS_COMPLETE
  } cls_e;

  function automatic cls_e classify_code(input code_t c);
    cls_e r;
    case (c)
      IC_SEGX, IC_PAGEX, IC_ASCTYPE, IC_RGN1X, IC_RGN2X, IC_RGN3X:
        r = CLS_XLATE;
      IC_PROT:
        r = CLS_PROT;
      IC_OPER, IC_PRIV, IC_EXEC, IC_ADDR, IC_SPEC, IC_DATA,
      IC_FXOVF, IC_FXDIV, IC_DCOVF, IC_DCDIV, IC_HEXOVF, IC_HEXUNF,
      IC_HSIG, IC_HDIV, IC_XSPEC, IC_SPOP, IC_OPND, IC_HSQRT,
      IC_PCXSPEC, IC_ALSPEC, IC_MONITOR:
        r = CLS_COMPLETE;
      default:
        r = CLS_NONE;
    endcase
    return r;
  endfunction

  function automatic logic len_is_legal(input code_t c, input logic [7:0] len);
    logic even_ok;
    even_ok = (len == 8'd2) || (len == 8'd4) || (len == 8'd6);
    return even_ok || ((len == 8'd0) && (c == IC_SPEC));
  endfunction

  function automatic code_t merge_event(input code_t c, input logic pend);
    return pend ? (c | IC_EVENT) : c;
  endfunction

  function automatic logic [SLOT_W-1:0] step_to_slot(input logic [STEP_W-1:0] s);
    logic [SLOT_W-1:0] r;
    case (int'(s))
      STEP_EVT_ADDR: r = SLOT_EVT_ADDR;
      STEP_EVT_ID:   r = SLOT_EVT_ID;
      STEP_TEC:      r = SLOT_TEC;
      STEP_ILEN:     r = SLOT_ILEN;
      STEP_CODE:     r = SLOT_CODE;
      STEP_OMASK:    r = SLOT_OLD_MASK;
      STEP_OADDR:    r = SLOT_OLD_ADDR;
      default:       r = SLOT_BEA;
    endcase
    return r;
  endfunction

  // lowest enabled step at or above 'from'; MSB flags a hit
  function automatic logic [STEP_W:0] seek_step(input logic [STEP_CNT-1:0] mask,
                                                input int from);
    logic [STEP_W:0] r;
    r = '0;
    for (int i = STEP_CNT - 1; i >= 0; i--) begin
      if (mask[i] && (i >= from)) r = {1'b1, STEP_W'(i)};
    end
    return r;
  endfunction
endpackage

// File: rtl/pic_classify.sv
module pic_classify
  import pic_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic [CODE_W-1:0] code,
  input  logic [LEN_W-1:0]  len,
  output logic              advance,
  output logic              keep_tec,
  output logic              len_bad
);
  cls_e cls;

  always_comb begin
    cls      = classify_code(code);
    advance  = (cls == CLS_PROT) || (cls == CLS_COMPLETE);
    keep_tec = (cls == CLS_PROT) || (cls == CLS_XLATE);
    len_bad  = !len_is_legal(code, 8'(len));
  end
endmodule

// File: rtl/pic_seq.sv
module pic_seq
  import pic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [STEP_CNT-1:0] step_mask,
  output state_e              state,
  output logic [STEP_W-1:0]   step,
  output logic                accept,
  output logic                store_we,
  output logic                busy,
  output logic                done
);
  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W:0]   first_hit;
  logic [STEP_W:0]   next_hit;

  always_comb begin
    first_hit = seek_step(step_mask, 0);
    next_hit  = seek_step(step_mask, int'(step_q) + 1);
  end

  assign state    = state_q;
  assign step     = step_q;
  assign busy     = (state_q != ST_IDLE);
  assign accept   = start && (state_q == ST_IDLE);
  assign store_we = (state_q == ST_STORE);
  assign done     = (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) state_q <= ST_ADJUST;
        ST_ADJUST: begin
          step_q  <= first_hit[STEP_W-1:0];
          state_q <= first_hit[STEP_W] ? ST_STORE : ST_LOAD_NEW;
        end
        ST_STORE: begin
          if (next_hit[STEP_W]) step_q <= next_hit[STEP_W-1:0];
          else                  state_q <= ST_LOAD_NEW;
        end
        ST_LOAD_NEW: state_q <= ST_DONE;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pic_save_area.sv
module pic_save_area #(
  parameter int DATA_W = 64,
  parameter int SLOTS  = 10,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  ridx_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mem[g] <= '0;
      else if (we && (widx == IDX_W'(g)))   mem[g] <= wdata;
    end
  end

  assign rdata_a = (ridx_a < IDX_W'(SLOTS)) ? mem[ridx_a] : '0;
  assign rdata_b = (ridx_b < IDX_W'(SLOTS)) ? mem[ridx_b] : '0;
endmodule

// File: rtl/pgm_int_complete.sv
module pgm_int_complete
  import pic_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [15:0]         code_i,
  input  logic [LEN_W-1:0]    ilen_i,
  input  logic [DATA_W-1:0]   psw_mask_i,
  input  logic [ADDR_W-1:0]   psw_addr_i,
  input  logic [15:0]         evt_id_i,
  input  logic [ADDR_W-1:0]   evt_addr_i,
  input  logic [DATA_W-1:0]   tec_i,
  input  logic [ADDR_W-1:0]   bea_i,
  input  logic                pre_we,
  input  logic [3:0]          pre_idx,
  input  logic [DATA_W-1:0]   pre_data,
  output logic                busy,
  output logic                done,
  output logic                evt_ack,
  output logic                len_err,
  output logic [ADDR_W-1:0]   old_addr_o,
  output logic [15:0]         final_code_o,
  output logic [LEN_W-1:0]    ilen_o,
  output logic                sa_we,
  output logic [3:0]          sa_idx,
  output logic [DATA_W-1:0]   sa_wdata,
  output logic [DATA_W-1:0]   psw_mask_o,
  output logic [ADDR_W-1:0]   psw_addr_o
);
  // captured request
  logic [15:0]       cap_code;
  logic [LEN_W-1:0]  cap_len;
  logic [DATA_W-1:0] cap_mask;
  logic [ADDR_W-1:0] cap_addr;
  logic [15:0]       cap_evt_id;
  logic [ADDR_W-1:0] cap_evt_addr;
  logic [DATA_W-1:0] cap_tec;
  logic [ADDR_W-1:0] cap_bea;

  // named internal events
  logic                accept_w;
  logic                advance_w;
  logic                keep_tec_w;
  logic                len_bad_w;
  logic                evt_pend_w;
  logic                store_we_w;
  logic [STEP_W-1:0]   step_w;
  logic [STEP_CNT-1:0] step_mask_w;
  logic [SLOT_W-1:0]   slot_w;
  logic [DATA_W-1:0]   seq_wdata_w;
  state_e              state_w;

  logic [ADDR_W-1:0] old_addr_q;
  logic [15:0]       final_code_q;
  logic              len_err_q;
  logic [DATA_W-1:0] psw_mask_q;
  logic [ADDR_W-1:0] psw_addr_q;

  logic              rf_we;
  logic [3:0]        rf_widx;
  logic [DATA_W-1:0] rf_wdata;
  logic [DATA_W-1:0] new_mask_w;
  logic [DATA_W-1:0] new_addr_w;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [LEN_W-1:0]  l,
                                                  input logic              adv);
    return adv ? (a + ADDR_W'(l)) : a;
  endfunction

  pic_classify #(.LEN_W(LEN_W)) u_cls (
    .code     (cap_code),
    .len      (cap_len),
    .advance  (advance_w),
    .keep_tec (keep_tec_w),
    .len_bad  (len_bad_w)
  );

  assign evt_pend_w = |cap_evt_id;

  always_comb begin
    step_mask_w                = '1;
    step_mask_w[STEP_EVT_ADDR] = evt_pend_w;
    step_mask_w[STEP_EVT_ID]   = evt_pend_w;
    step_mask_w[STEP_TEC]      = keep_tec_w;
  end

  pic_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step_mask (step_mask_w),
    .state     (state_w),
    .step      (step_w),
    .accept    (accept_w),
    .store_we  (store_we_w),
    .busy      (busy),
    .done      (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_code     <= '0;
      cap_len      <= '0;
      cap_mask     <= '0;
      cap_addr     <= '0;
      cap_evt_id   <= '0;
      cap_evt_addr <= '0;
      cap_tec      <= '0;
      cap_bea      <= '0;
    end else if (accept_w) begin
      cap_code     <= code_i;
      cap_len      <= ilen_i;
      cap_mask     <= psw_mask_i;
      cap_addr     <= psw_addr_i;
      cap_evt_id   <= evt_id_i;
      cap_evt_addr <= evt_addr_i;
      cap_tec      <= tec_i;
      cap_bea      <= bea_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_addr_q   <= '0;
      final_code_q <= '0;
      len_err_q    <= 1'b0;
    end else if (state_w == ST_ADJUST) begin
      old_addr_q   <= step_addr(cap_addr, cap_len, advance_w);
      final_code_q <= merge_event(cap_code, evt_pend_w);
      len_err_q    <= len_bad_w;
    end
  end

  assign slot_w = step_to_slot(step_w);

  always_comb begin
    case (slot_w)
      SLOT_EVT_ADDR: seq_wdata_w = DATA_W'(cap_evt_addr);
      SLOT_EVT_ID:   seq_wdata_w = DATA_W'(cap_evt_id);
      SLOT_TEC:      seq_wdata_w = cap_tec;
      SLOT_ILEN:     seq_wdata_w = DATA_W'(cap_len);
      SLOT_CODE:     seq_wdata_w = DATA_W'(final_code_q);
      SLOT_OLD_MASK: seq_wdata_w = cap_mask;
      SLOT_OLD_ADDR: seq_wdata_w = DATA_W'(old_addr_q);
      SLOT_BEA:      seq_wdata_w = DATA_W'(cap_bea);
      default:       seq_wdata_w = '0;
    endcase
  end

  // sequence writes own the port; preload only while idle
  assign rf_we    = store_we_w || (pre_we && !busy);
  assign rf_widx  = store_we_w ? slot_w : pre_idx;
  assign rf_wdata = store_we_w ? seq_wdata_w : pre_data;

  pic_save_area #(.DATA_W(DATA_W), .SLOTS(SLOT_CNT), .IDX_W(SLOT_W)) u_sa (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .widx    (rf_widx),
    .wdata   (rf_wdata),
    .ridx_a  (SLOT_NEW_MASK),
    .rdata_a (new_mask_w),
    .ridx_b  (SLOT_NEW_ADDR),
    .rdata_b (new_addr_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_mask_q <= '0;
      psw_addr_q <= '0;
    end else if (state_w == ST_LOAD_NEW) begin
      psw_mask_q <= new_mask_w;
      psw_addr_q <= new_addr_w[ADDR_W-1:0];
    end
  end

  assign evt_ack      = done && evt_pend_w;
  assign len_err      = len_err_q;
  assign old_addr_o   = old_addr_q;
  assign final_code_o = final_code_q;
  assign ilen_o       = cap_len;
  assign sa_we        = store_we_w;
  assign sa_idx       = slot_w;
  assign sa_wdata     = seq_wdata_w;
  assign psw_mask_o   = psw_mask_q;
  assign psw_addr_o   = psw_addr_q;
endmodule

// File: rtl/pgm_int_complete_chk.sv
module pgm_int_complete_chk #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              evt_ack,
  input logic              len_err,
  input logic              sa_we,
  input logic [3:0]        sa_idx,
  input logic [15:0]       code_i,
  input logic [LEN_W-1:0]  ilen_i,
  input logic [ADDR_W-1:0] psw_addr_i,
  input logic [ADDR_W-1:0] old_addr_o,
  input logic [15:0]       final_code_o
);
  logic [ADDR_W-1:0] ck_addr;
  logic [LEN_W-1:0]  ck_len;
  logic [15:0]       ck_code;
  logic              ck_bea_seen;
  logic              ck_len_even;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_addr     <= '0;
      ck_len      <= '0;
      ck_code     <= '0;
      ck_bea_seen <= 1'b0;
    end else if (start && !busy) begin
      ck_addr     <= psw_addr_i;
      ck_len      <= ilen_i;
      ck_code     <= code_i;
      ck_bea_seen <= 1'b0;
    end else if (sa_we && (sa_idx == pic_pkg::SLOT_BEA)) begin
      ck_bea_seen <= 1'b1;
    end
  end

  assign ck_len_even = (ck_len == LEN_W'(2)) || (ck_len == LEN_W'(4)) ||
                       (ck_len == LEN_W'(6));

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sa_we |-> busy); // R8
  AST_EVT_ACK_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ack |-> (done && final_code_o[7])); // R7
  AST_CODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((final_code_o | 16'h0080) == (ck_code | 16'h0080))); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((old_addr_o == ck_addr) || (old_addr_o == ck_addr + ADDR_W'(ck_len)))); // R5
  AST_LEN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ck_len_even) |-> !len_err); // R2
  AST_BEA_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ck_bea_seen); // R9
endmodule

bind pgm_int_complete pgm_int_complete_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .evt_ack      (evt_ack),
  .len_err      (len_err),
  .sa_we        (sa_we),
  .sa_idx       (sa_idx),
  .code_i       (code_i),
  .ilen_i       (ilen_i),
  .psw_addr_i   (psw_addr_i),
  .old_addr_o   (old_addr_o),
  .final_code_o (final_code_o)
);

// File: tb/pgm_int_complete_tb.sv
`timescale 1ns/1ps
module pgm_int_complete_tb;
  localparam int DW = 64;
  localparam int AW = 64;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [15:0]   code_i = '0;
  logic [LW-1:0] ilen_i = '0;
  logic [DW-1:0] psw_mask_i = '0;
  logic [AW-1:0] psw_addr_i = '0;
  logic [15:0]   evt_id_i = '0;
  logic [AW-1:0] evt_addr_i = '0;
  logic [DW-1:0] tec_i = '0;
  logic [AW-1:0] bea_i = '0;
  logic          pre_we = 1'b0;
  logic [3:0]    pre_idx = '0;
  logic [DW-1:0] pre_data = '0;
  logic          busy, done, evt_ack, len_err, sa_we;
  logic [AW-1:0] old_addr_o, psw_addr_o;
  logic [15:0]   final_code_o;
  logic [LW-1:0] ilen_o;
  logic [3:0]    sa_idx;
  logic [DW-1:0] sa_wdata, psw_mask_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pgm_int_complete #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .code_i(code_i), .ilen_i(ilen_i),
    .psw_mask_i(psw_mask_i), .psw_addr_i(psw_addr_i), .evt_id_i(evt_id_i),
    .evt_addr_i(evt_addr_i), .tec_i(tec_i), .bea_i(bea_i), .pre_we(pre_we),
    .pre_idx(pre_idx), .pre_data(pre_data), .busy(busy), .done(done),
    .evt_ack(evt_ack), .len_err(len_err), .old_addr_o(old_addr_o),
    .final_code_o(final_code_o), .ilen_o(ilen_o), .sa_we(sa_we), .sa_idx(sa_idx),
    .sa_wdata(sa_wdata), .psw_mask_o(psw_mask_o), .psw_addr_o(psw_addr_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // 0 none, 1 translation, 2 protection, 3 completing
  function automatic int kind_of(input logic [15:0] c);
    if (c == 16'h0004) return 2;
    if (c == 16'h0010 || c == 16'h0011 || (c >= 16'h0038 && c <= 16'h003B)) return 1;
    if ((c >= 16'h0001 && c <= 16'h000F) || c == 16'h0012 || c == 16'h0013 ||
        c == 16'h0015 || c == 16'h001D || c == 16'h001F || c == 16'h0028 ||
        c == 16'h0040) return 3;
    return 0;
  endfunction

  function automatic string kind_req(input int k);
    case (k)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_one(input logic [15:0] c, input logic [LW-1:0] l,
                         input logic [15:0] eid, input logic [AW-1:0] addr,
                         input int tag, input bit disturb);
    logic [3:0]  oi [16];
    logic [63:0] od [16];
    logic [3:0]  ei [16];
    logic [63:0] ed [16];
    int n, ne, k;
    bit got;
    logic [63:0] nm, na, mk, tc, ea, be, adj;
    logic [15:0] fc;
    logic [AW-1:0] s_old, s_pa;
    logic [15:0] s_code;
    logic [DW-1:0] s_pm;
    logic s_le, s_ack;
    bit exp_le;

    nm = 64'hA5A5_0000_0000_0000 ^ 64'(tag);
    na = 64'h0000_0000_0002_0000 + 64'(tag) * 8;
    mk = 64'h0705_0000_8000_0000 + 64'(tag);
    tc = 64'h0000_0000_00C0_0000 | 64'(tag);
    ea = 64'h0000_0000_0090_0000 + 64'(tag) * 4;
    be = 64'h0000_0000_0070_0000 + 64'(tag) * 2;
    @(negedge clk); pre_we = 1'b1; pre_idx = 4'd2; pre_data = nm;
    @(negedge clk); pre_idx = 4'd3; pre_data = na;
    @(negedge clk); pre_we = 1'b0;
    code_i = c; ilen_i = l; evt_id_i = eid; psw_addr_i = addr; psw_mask_i = mk;
    tec_i = tc; evt_addr_i = ea; bea_i = be; start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0; got = 0; k = 0;
    s_old = '0; s_pa = '0; s_code = '0; s_pm = '0; s_le = 0; s_ack = 0;
    while (k < 40 && !got) begin
      if (disturb && k == 2) begin
        start = 1'b1; code_i = 16'h0011; pre_we = 1'b1; pre_idx = 4'd3;
        pre_data = 64'hDEAD_0000_0000_BEEF;
      end else begin
        start = 1'b0; pre_we = 1'b0;
      end
      if (sa_we && n < 16) begin oi[n] = sa_idx; od[n] = sa_wdata; n++; end
      if (done) begin
        got = 1; s_old = old_addr_o; s_code = final_code_o; s_le = len_err;
        s_ack = evt_ack; s_pm = psw_mask_o; s_pa = psw_addr_o;
      end else @(negedge clk);
      k++;
    end
    start = 1'b0; pre_we = 1'b0;
    chk(got == 1, "R10", "done seen", 64'(got), 64'd1);
    if (!got) return;

    // expected results
    adj = (kind_of(c) >= 2) ? addr + AW'(l) : addr;
    fc  = (eid != 0) ? (c | 16'h0080) : c;
    exp_le = !((l == 2) || (l == 4) || (l == 6) || (l == 0 && c == 16'h0006));
    ne = 0;
    if (eid != 0) begin
      ei[ne] = 4'd5; ed[ne] = ea; ne++;
      ei[ne] = 4'd6; ed[ne] = 64'(eid); ne++;
    end
    if (kind_of(c) == 1 || kind_of(c) == 2) begin ei[ne] = 4'd4; ed[ne] = tc; ne++; end
    ei[ne] = 4'd7; ed[ne] = 64'(l);  ne++;
    ei[ne] = 4'd8; ed[ne] = 64'(fc); ne++;
    ei[ne] = 4'd0; ed[ne] = mk;      ne++;
    ei[ne] = 4'd1; ed[ne] = adj;     ne++;
    ei[ne] = 4'd9; ed[ne] = be;      ne++;

    chk(s_old == adj, kind_req(kind_of(c)), "old address", s_old, adj);
    chk(s_code == fc, "R7", "final code", 64'(s_code), 64'(fc));
    chk(s_ack == (eid != 0), "R7", "event ack", 64'(s_ack), 64'(eid != 0));
    chk(s_le == exp_le, "R2", "length flag", 64'(s_le), 64'(exp_le));
    chk(s_pm == nm, "R11", "new mask", s_pm, nm);
    chk(s_pa == na, "R11", "new address", s_pa, na);
    chk(n == ne, "R8", "write count", 64'(n), 64'(ne));
    for (int i = 0; i < ne && i < n; i++) begin
      string rq;
      rq = (ei[i] == 4'd5 || ei[i] == 4'd6) ? "R7" :
           (ei[i] == 4'd4) ? kind_req(kind_of(c)) :
           (ei[i] == 4'd9) ? "R9" : "R8";
      chk(oi[i] == ei[i], rq, "write slot", 64'(oi[i]), 64'(ei[i]));
      chk(od[i] == ed[i], rq, "write data", od[i], ed[i]);
    end
    if (disturb) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        chk(!busy && !sa_we, "R10", "no restart after busy start", 64'(busy), 64'd0);
      end
    end
  endtask

  initial begin
    logic [15:0] codes [35];
    logic [LW-1:0] lens [5];
    int tag;
    for (int i = 0; i <= 16'h16; i++) codes[i] = 16'(i);
    codes[23] = 16'h001D; codes[24] = 16'h001F; codes[25] = 16'h0028;
    codes[26] = 16'h0038; codes[27] = 16'h0039; codes[28] = 16'h003A;
    codes[29] = 16'h003B; codes[30] = 16'h003F; codes[31] = 16'h0040;
    codes[32] = 16'h0041; codes[33] = 16'h0080; codes[34] = 16'h0084;
    lens[0] = 3'd0; lens[1] = 3'd1; lens[2] = 3'd2; lens[3] = 3'd4; lens[4] = 3'd6;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !sa_we, "R1", "idle after reset", {61'd0, busy, done, sa_we}, 64'd0);
    chk(!len_err && !evt_ack, "R1", "flags after reset", {62'd0, len_err, evt_ack}, 64'd0);
    chk(psw_addr_o == '0 && psw_mask_o == '0, "R1", "psw after reset", psw_addr_o, 64'd0);

    tag = 0;
    for (int ci = 0; ci < 35; ci++) begin
      for (int li = 0; li < 5; li++) begin
        for (int e = 0; e < 2; e++) begin
          logic [AW-1:0] a;
          a = (tag % 7 == 0) ? 64'hFFFF_FFFF_FFFF_FFFE : 64'h0000_1000_0000_0000 + 64'(tag) * 16;
          run_one(codes[ci], lens[li], (e == 1) ? 16'h1200 + 16'(ci) : 16'h0000, a, tag, 1'b0);
          tag++;
        end
      end
    end
    // start and preload while busy are dropped
    run_one(16'h0004, 3'd4, 16'h0000, 64'h0000_0000_0000_4000, tag, 1'b1);
    run_one(16'h0080, 3'd2, 16'h0031, 64'h0000_0000_0000_5000, tag + 1, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL R10 watchdog actual=%h expected=%h", 64'd1, 64'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule